// File: doc/BRIEF.md
# Complement-Keyed Watchdog Timer

This block watches over software through one write-only control port. It stays idle from power-up until the first write. That write arms it, fixes an 8-bit key and loads the timeout. From then on the watchdog cannot be turned off.

The timeout runs on an 8-bit down-counter. The counter steps once for every `PRESCALE` enabled clocks. When it steps below zero it wraps to all ones, raises a reset request for a fixed number of clocks and sets a sticky error flag. To keep the counter from running out, software writes the key and its bit complement in turn. Later-even writes go to one trigger register and later-odd writes go to another. The counter reloads only when the two registers hold bitwise complementary values.

A wrong value sets the flag at once and locks out all further reloads. After that the timeout always expires. A slow-mode input lets the prescaler advance only on an external rate tick. A supply-supervision reset clears the flag but never disarms the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset (`por_n_i` low) the block is disarmed. `rst_req_o` and `wd_err_o` are 0, the timeout register is FFh and both trigger registers are 00h. While disarmed, `rst_req_o` never rises, however much time passes.
- R2: The first write after power-on arms the block. It stores the write data as the key and as the timeout value, loads the down-counter with it and clears the prescaler.
- R3: While armed, the counter decrements once every `PRESCALE` enabled clocks. A step taken at 00h wraps the counter to FFh. `rst_req_o` then goes high in the cycle after that edge and stays high for exactly `PULSE_LEN` cycles.
- R4: Write number 2, 4, 6 and so on loads trigger register A and is expected to equal the key. Write number 3, 5, 7 and so on loads trigger register B and is expected to equal the bitwise complement of the key.
- R5: A write that matches its expected value reloads the counter from the timeout register when the lock is clear and, after that write, trigger A XOR trigger B equals FFh. A watchdog expiry in the same cycle takes priority over the reload, and so does a supply reset.
- R6: A write that does not match its expected value sets `wd_err_o` and the lock. While the lock is set, no write reloads the counter. Only power-on reset clears the lock.
- R7: `wd_err_o` is set by a watchdog expiry or a mismatching write. It is cleared by `sup_rst_i` or by any write that does not itself mismatch. When set and clear fall in the same cycle, set wins.
- R8: A watchdog expiry or a `sup_rst_i` cycle sets the timeout register and the counter to FFh and leaves the key, the write parity, the armed state and the lock unchanged. A supply reset also clears the prescaler.
- R9: With `slow_i` high, the prescaler advances only in cycles where `slow_tick_i` is high.
- R10: Once armed, the block stays armed through supply resets and its own expiries. It keeps timing out while no valid retrigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| sup_rst_i | input | 1 | Supply-supervision reset, synchronous, active high |
| slow_i | input | 1 | Slow mode: prescaler advances only on `slow_tick_i` |
| slow_tick_i | input | 1 | Reduced-rate enable used in slow mode |
| wr_i | input | 1 | Control register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rst_req_o | output | 1 | Reset request pulse, `PULSE_LEN` cycles |
| wd_err_o | output | 1 | Sticky watchdog error flag |

## Verification
The embedded assertions check the following on every cycle:
- the lock and the armed state are sticky;
- a mismatching write raises the flag on the next cycle;
- a zero-count step wraps the counter and starts the request pulse;
- a reload takes the timeout value;
- the prescaler holds between slow-mode ticks;
- no request appears while the block is disarmed.

Other behaviours need the bench's write sequences to show them:
- the second write alone does not retrigger;
- after an expiry the reload interval becomes the maximum;
- a supply reset leaves the lock in force;
- set beats clear when a wrong write coincides with a supply reset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   // Classification of a control-register write
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_ARM  = 2'd1,
      WR_EVEN = 2'd2,
      WR_ODD  = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int PRESCALE = 8192
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic run_i,
   input  logic clr_i,
   input  logic slow_i,
   input  logic slow_tick_i,
   output logic step_o
);

   logic adv;
   assign adv = run_i && (!slow_i || slow_tick_i);

   generate
      if (PRESCALE == 1) begin : g_direct
         assign step_o = adv;
      end else begin : g_count
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

         logic [PW-1:0] pcnt_q;

         assign step_o = adv && (pcnt_q == LAST);

         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) begin
               pcnt_q <= '0;
            end else if (clr_i) begin
               pcnt_q <= '0;
            end else if (step_o) begin
               pcnt_q <= '0;
            end else if (adv) begin
               pcnt_q <= pcnt_q + 1'b1;
            end
         end

         // R9: between slow-mode ticks the prescaler must not move
         p_slow_hold_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
            (slow_i && !slow_tick_i && !clr_i) |=> $stable(pcnt_q));
      end
   endgenerate

endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
   import kwd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         por_n_i,
   input  logic         wr_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         sup_rst_i,
   input  logic         fire_i,
   output logic         armed_o,
   output logic         arm_wr_o,
   output logic         reload_o,
   output logic         err_o
);

   logic         armed_q;
   logic         even_q;
   logic         lock_q;
   logic         err_q;
   logic [W-1:0] key_q;
   logic [W-1:0] trig_a_q;
   logic [W-1:0] trig_b_q;

   wr_kind_e     kind;
   logic         bad;
   logic [W-1:0] trig_a_n;
   logic [W-1:0] trig_b_n;

   always_comb begin
      if (!wr_i)        kind = WR_NONE;
      else if (!armed_q) kind = WR_ARM;
      else if (even_q)   kind = WR_EVEN;
      else               kind = WR_ODD;
   end

   always_comb begin
      bad      = 1'b0;
      trig_a_n = trig_a_q;
      trig_b_n = trig_b_q;
      case (kind)
         WR_EVEN: begin
            bad      = (wr_data_i != key_q);
            trig_a_n = wr_data_i;
         end
         WR_ODD: begin
            bad      = (wr_data_i != ~key_q);
            trig_b_n = wr_data_i;
         end
         default: ;
      endcase
   end

   assign reload_o = ((kind == WR_EVEN) || (kind == WR_ODD)) && !bad && !lock_q
                     && ((trig_a_n ^ trig_b_n) == {W{1'b1}});
   assign arm_wr_o = (kind == WR_ARM);
   assign armed_o  = armed_q;
   assign err_o    = err_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         armed_q  <= 1'b0;
         even_q   <= 1'b0;
         lock_q   <= 1'b0;
         err_q    <= 1'b0;
         key_q    <= '0;
         trig_a_q <= '0;
         trig_b_q <= '0;
      end else begin
         if (kind == WR_ARM) begin
            armed_q <= 1'b1;
            key_q   <= wr_data_i;
            even_q  <= 1'b1;
         end else if (kind != WR_NONE) begin
            even_q <= ~even_q;
         end
         trig_a_q <= trig_a_n;
         trig_b_q <= trig_b_n;
         if (bad) lock_q <= 1'b1;
         if (bad || fire_i)        err_q <= 1'b1;
         else if (sup_rst_i || wr_i) err_q <= 1'b0;
      end
   end

   // R6: the lock is never released without power-on reset
   p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      lock_q |=> lock_q);
   // R6: a mismatching write raises the flag
   p_bad_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      bad |=> err_q);
   // R10: armed state cannot be dropped
   p_armed_sticky_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
      armed_q |=> armed_q);

endmodule

// File: rtl/kwd_downcnt.sv
module kwd_downcnt #(
   parameter int W         = 8,
   parameter int PULSE_LEN = 4
) (
   input  logic         clk_i,
   input  logic         por_n_i,
   input  logic         step_i,
   input  logic         sup_rst_i,
   input  logic         arm_wr_i,
   input  logic [W-1:0] arm_val_i,
   input  logic         reload_i,
   output logic         fire_o,
   output logic         rst_req_o
);

   localparam int QW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
   localparam logic [QW-1:0] QLOAD = QW'(PULSE_LEN - 1);

   logic [W-1:0]  cnt_q;
   logic [W-1:0]  tmo_q;
   logic [QW-1:0] pcnt_q;
   logic          req_q;

   assign fire_o    = step_i && (cnt_q == '0);
   assign rst_req_o = req_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '1;
         tmo_q <= '1;
      end else begin
         if (fire_o || sup_rst_i) tmo_q <= '1;
         else if (arm_wr_i)       tmo_q <= arm_val_i;

         if (fire_o || sup_rst_i) cnt_q <= '1;
         else if (arm_wr_i)       cnt_q <= arm_val_i;
         else if (reload_i)       cnt_q <= tmo_q;
         else if (step_i)         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         req_q  <= 1'b0;
         pcnt_q <= '0;
      end else if (fire_o) begin
         req_q  <= 1'b1;
         pcnt_q <= QLOAD;
      end else if (req_q) begin
         if (pcnt_q == '0) req_q <= 1'b0;
         else              pcnt_q <= pcnt_q - 1'b1;
      end
   end

   // R3: a zero-count step wraps to all ones and starts the request
   p_wrap_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (step_i && cnt_q == '0) |=> (cnt_q == '1) && req_q);
   // R3: the request ends only once the pulse length is used up
   p_pulse_end_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $fell(req_q) |-> ($past(pcnt_q) == '0));
   // R5: a retrigger loads the timeout value
   p_reload_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (reload_i && !fire_o && !sup_rst_i) |=> (cnt_q == $past(tmo_q)));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int DATA_W    = 8,
   parameter int PRESCALE  = 8192,
   parameter int PULSE_LEN = 4
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              sup_rst_i,
   input  logic              slow_i,
   input  logic              slow_tick_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              rst_req_o,
   output logic              wd_err_o
);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("keyed_watchdog: DATA_W must be at least 2");
      end
      if (PRESCALE < 1) begin : g_bad_p
         $error("keyed_watchdog: PRESCALE must be at least 1");
      end
      if (PULSE_LEN < 1) begin : g_bad_l
         $error("keyed_watchdog: PULSE_LEN must be at least 1");
      end
   endgenerate

   logic armed;
   logic arm_wr;
   logic reload;
   logic step;
   logic fire;

   kwd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk_i       (clk_i),
      .por_n_i     (por_n_i),
      .run_i       (armed),
      .clr_i       (sup_rst_i || arm_wr),
      .slow_i      (slow_i),
      .slow_tick_i (slow_tick_i),
      .step_o      (step)
   );

   kwd_keyseq #(.W(DATA_W)) u_seq (
      .clk_i     (clk_i),
      .por_n_i   (por_n_i),
      .wr_i      (wr_i),
      .wr_data_i (wr_data_i),
      .sup_rst_i (sup_rst_i),
      .fire_i    (fire),
      .armed_o   (armed),
      .arm_wr_o  (arm_wr),
      .reload_o  (reload),
      .err_o     (wd_err_o)
   );

   kwd_downcnt #(.W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
      .clk_i     (clk_i),
      .por_n_i   (por_n_i),
      .step_i    (step),
      .sup_rst_i (sup_rst_i),
      .arm_wr_i  (arm_wr),
      .arm_val_i (wr_data_i),
      .reload_i  (reload),
      .fire_o    (fire),
      .rst_req_o (rst_req_o)
   );

   // R1: no request can come from a disarmed block
   p_unarmed_quiet_r1: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !armed |-> !rst_req_o);

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

   localparam int P  = 4;
   localparam int PL = 4;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sup_rst = 1'b0;
   logic       slow = 1'b0;
   logic       slow_tick = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       rst_req;
   logic       wd_err;

   always #4 clk = ~clk;

   keyed_watchdog #(.DATA_W(8), .PRESCALE(P), .PULSE_LEN(PL)) u_dut (
      .clk_i       (clk),
      .por_n_i     (por_n),
      .sup_rst_i   (sup_rst),
      .slow_i      (slow),
      .slow_tick_i (slow_tick),
      .wr_i        (wr),
      .wr_data_i   (wdata),
      .rst_req_o   (rst_req),
      .wd_err_o    (wd_err)
   );

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   int    rst_cycles = 0;
   string tag = "R1";
   bit    done = 0;

   // behavioural reference
   int m_armed, m_key, m_tmo, m_cnt, m_pre, m_ta, m_tb, m_even, m_lock, m_flag, m_pulse;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_armed = 0; m_key = 0; m_tmo = 255; m_cnt = 255; m_pre = 0;
         m_ta = 0; m_tb = 0; m_even = 0; m_lock = 0; m_flag = 0; m_pulse = 0;
      end else begin : mdl
         int adv, stp, fire, bad, rl, na, nb, istrig, isarm;
         adv    = (m_armed != 0) && (!slow || slow_tick);
         stp    = adv && (m_pre == P - 1);
         fire   = stp && (m_cnt == 0);
         isarm  = wr && (m_armed == 0);
         istrig = wr && (m_armed != 0);
         bad = 0; na = m_ta; nb = m_tb;
         if (istrig && m_even != 0) begin
            na = wdata; bad = (wdata != m_key);
         end else if (istrig) begin
            nb = wdata; bad = (wdata != (m_key ^ 255));
         end
         rl = istrig && !bad && (m_lock == 0) && ((na ^ nb) == 255);
         if (sup_rst || isarm) m_pre = 0;
         else if (adv) m_pre = (m_pre + 1) % P;
         if (fire || sup_rst) begin
            m_tmo = 255; m_cnt = 255;
         end else if (isarm) begin
            m_tmo = wdata; m_cnt = wdata;
         end else if (rl) m_cnt = m_tmo;
         else if (stp) m_cnt = m_cnt - 1;
         if (isarm) begin m_armed = 1; m_key = wdata; m_even = 1; end
         else if (istrig) m_even = 1 - m_even;
         m_ta = na; m_tb = nb;
         if (bad) m_lock = 1;
         if (bad || fire) m_flag = 1;
         else if (sup_rst || wr) m_flag = 0;
         if (fire) m_pulse = PL;
         else if (m_pulse > 0) m_pulse = m_pulse - 1;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the reference, plus watchdog
   always @(negedge clk) begin
      cycles++;
      if (por_n && !done) begin
         check(tag, "rst_req_o vs model", int'(rst_req), int'(m_pulse > 0));
         check(tag, "wd_err_o vs model", int'(wd_err), m_flag);
         if (rst_req) rst_cycles++;
      end
      if (cycles > 190000 && !done) begin
         errors++;
         $display("FAIL watchdog run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   int tb_key;
   int tb_even;

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write(int d);
      @(negedge clk);
      wr = 1'b1; wdata = 8'(d);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic arm(int d);
      tb_key = d; tb_even = 1;
      write(d);
   endtask

   task automatic good_write();
      write(tb_even ? tb_key : (tb_key ^ 255));
      tb_even = 1 - tb_even;
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      idle(3);
      por_n = 1'b1;
      rst_cycles = 0;
   endtask

   initial begin
      idle(3);
      por_n = 1'b1;
      @(negedge clk);
      // R1: reset state and no request while disarmed
      tag = "R1";
      check("R1", "rst_req_o after reset", int'(rst_req), 0);
      check("R1", "wd_err_o after reset", int'(wd_err), 0);
      idle(2000);
      check("R1", "no request while disarmed", rst_cycles, 0);

      // R2/R3: arm with 05h, no retrigger -> one pulse of PL cycles
      tag = "R3";
      arm(8'h05);
      idle(40);
      check("R3", "pulse length after first timeout", rst_cycles, PL);
      check("R7", "flag set by expiry", int'(wd_err), 1);

      // R10/R8: stays armed, expires again with maximum interval
      tag = "R10";
      idle(1100);
      check("R10", "second expiry without writes", rst_cycles, 2 * PL);

      // R4/R5: regular alternating writes keep it quiet
      power_on();
      tag = "R5";
      arm(8'h10);
      for (int i = 0; i < 30; i++) begin
         idle(15);
         good_write();
      end
      check("R5", "no request under correct retriggering", rst_cycles, 0);
      check("R4", "no error under correct sequence", int'(wd_err), 0);

      // R7: expiry then a correct write clears the flag
      tag = "R7";
      idle(80);
      check("R7", "expiry after writes stop", rst_cycles, PL);
      check("R7", "flag set by expiry", int'(wd_err), 1);
      good_write();
      check("R7", "flag cleared by valid write", int'(wd_err), 0);

      // R8: reload source is now FFh, so 500 cycles without writes is safe
      tag = "R8";
      good_write();
      idle(500);
      check("R8", "reload interval is maximum after expiry", rst_cycles, PL);

      // R6: wrong value locks out retriggering
      tag = "R6";
      write(8'h33);
      tb_even = 1 - tb_even;
      check("R6", "flag set by wrong write", int'(wd_err), 1);
      rst_cycles = 0;
      for (int i = 0; i < 80; i++) begin
         idle(14);
         good_write();
      end
      check("R6", "expiry despite correct writes when locked", rst_cycles, PL);

      // R7: set beats clear with supply reset and wrong write together
      tag = "R7";
      @(negedge clk);
      sup_rst = 1'b1; wr = 1'b1; wdata = 8'h77;
      @(negedge clk);
      sup_rst = 1'b0; wr = 1'b0;
      tb_even = 1 - tb_even;
      check("R7", "set wins over clear", int'(wd_err), 1);
      @(negedge clk);
      sup_rst = 1'b1;
      @(negedge clk);
      sup_rst = 1'b0;
      check("R7", "supply reset clears flag", int'(wd_err), 0);

      // R6/R10: lock and arming survive a supply reset
      tag = "R10";
      rst_cycles = 0;
      for (int i = 0; i < 80; i++) begin
         idle(14);
         good_write();
      end
      check("R6", "lock survives supply reset", rst_cycles, PL);

      // R9: slow mode stretches the timeout
      power_on();
      tag = "R9";
      slow = 1'b1;
      fork
         begin
            while (slow) begin
               @(negedge clk); slow_tick = 1'b1;
               @(negedge clk); slow_tick = 1'b0;
               idle(2);
            end
         end
         begin
            arm(8'h05);
            idle(60);
            check("R9", "no request at normal-rate timeout", rst_cycles, 0);
            idle(80);
            check("R9", "request at reduced-rate timeout", rst_cycles, PL);
            slow = 1'b0;
         end
      join

      // R1: power-on reset disarms
      power_on();
      tag = "R1";
      idle(1500);
      check("R1", "disarmed after power-on reset", rst_cycles, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule